// File: doc/BRIEF.md
# Triple-Redundant Register Pipeline with Distributed Voting

This block is a short datapath of registers in which every flip-flop and every piece of next-state logic exists three times. All three copies run from one shared clock and one shared synchronous reset. A single-copy input word is fanned out to the three copies at the entry. Stage outputs are voted per copy, and the last stage is a running accumulator. At the exit a merging voter turns the three copies back into one word for unprotected logic downstream.

Each voted stage has three majority voters, one per copy, placed right after the registers. The voted values feed the next stage and the stage's own hold or feedback path, so a copy that took an upset is rewritten from the majority on the following edge.

The first stage is always enabled and has no feedback, so it carries no voters: its three raw copies go straight to the second stage. A fault-injection input for each copy of each stage lets a bench upset one copy on purpose. A disagreement flag shows when the copies of any stage differ.

Top module: `tmr_pipe_chain`

## Requirements
- R1: Every voter output bit is 1 exactly when at least two of its three input bits are 1. The merged output `dout` is therefore unaffected by a single corrupted copy at any stage.
- R2: While `rst_n` is low at a rising clock edge, all copies of all registers become zero. In the cycle after that edge, `dout` is 0 and `mismatch` is 0.
- R3: Stage 0 loads `din` on every edge and has no voter. Middle stages 1 to STAGES-2 load their predecessor's output when `adv` is 1 and keep their own voted value when `adv` is 0.
- R4: The last stage is an accumulator. When `adv` is 1 it adds the previous stage's output to its own voted value, modulo 2^W. When `adv` is 0 it keeps its voted value, so `dout` does not change.
- R5: With `adv` held at 1, a `din` value sampled at edge k is added into the accumulator at edge k+STAGES-1. It is visible on `dout` after that edge.
- R6: Bit s*3+c of `flip` inverts every bit of the value that copy c of stage s stores at that edge. At most one bit of `flip` may be set at a time, with at least three clear edges between set bits. Under those conditions `dout` always equals the fault-free result.
- R7: `mismatch` is 1 whenever the copies of any stage differ. It is 1 in the cycle after any injected flip. It is also 1 in the second cycle after a stage-0 flip if `adv` was 1 at the edge in between. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for all three copies |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | W | Single-copy data input, fanned out to three copies |
| adv | input | 1 | Advance enable for middle stages and the accumulator |
| flip | input | 3*STAGES | Fault injection, bit s*3+c upsets copy c of stage s |
| dout | output | W | Merged (voted) accumulator value |
| mismatch | output | 1 | High while any stage's three copies disagree |

## Verification
The assertions assume that the fault injection stays within the single-upset model of R6. At most one `flip` bit is set per edge, and at least three clear edges separate two upsets, because a stage-0 upset can still be present one stage later. Two of the checker's properties confirm these input assumptions, and the stability and disagreement properties rely on them. The stimulus table and the directed tests place every upset at least four entries apart, and never set two injection bits in the same entry.

// File: rtl/tmr_pipe_pkg.sv
// Package: shared stage variants for the triple-redundant pipeline.
// Assumes nothing beyond being compiled before the modules that import it.
package tmr_pipe_pkg;

    // Kind of a voted stage: plain enabled register or feedback accumulator.
    typedef enum logic [1:0] {
        STG_HOLD  = 2'd1,
        STG_ACCUM = 2'd2
    } stage_kind_e;

endpackage

// File: rtl/tmr_vote3.sv
// Module: three-input bitwise majority voter.
// Each output bit is 1 when two or more of the matching input bits are 1.
// Assumes the three inputs are copies of the same word.
module tmr_vote3 #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] y
);

    // Majority of three per bit.
    always_comb begin
        y = (a & b) | (a & c) | (b & c);
    end

endmodule

// File: rtl/tmr_stage_raw.sv
// Module: always-enabled triplicated register stage without voters.
// Each copy loads its own input copy on every edge; outputs are the raw
// register copies. Assumes the stage is not part of any feedback loop.
module tmr_stage_raw #(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          flip,
    input  logic [2:0][W-1:0]   d,
    output logic [2:0][W-1:0]   q,
    output logic                disagree
);

    logic [2:0][W-1:0] cur;

    for (genvar c = 0; c < 3; c++) begin : g_copy
        logic [W-1:0] r_q;

        // Capture this copy's input, optionally inverted by fault injection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_q <= '0;
            end else begin
                r_q <= d[c] ^ {W{flip[c]}};
            end
        end

        assign cur[c] = r_q;
    end

    assign q = cur;

    // Flag any difference between the three stored copies.
    always_comb begin
        disagree = (cur[0] != cur[1]) || (cur[1] != cur[2]);
    end

endmodule

// File: rtl/tmr_stage_voted.sv
// Module: triplicated register stage with one majority voter per copy.
// The voted value of each copy is both the stage output and the source of
// that copy's hold or accumulate path, so an upset copy is rewritten from
// the majority on the next edge. Assumes at most one copy is wrong at a time.
module tmr_stage_voted
    import tmr_pipe_pkg::*;
#(
    parameter int          W    = 8,
    parameter stage_kind_e KIND = STG_HOLD
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [2:0]          flip,
    input  logic [2:0][W-1:0]   d,
    output logic [2:0][W-1:0]   q,
    output logic                disagree
);

    logic [2:0][W-1:0] cur;
    logic [2:0][W-1:0] voted;

    for (genvar c = 0; c < 3; c++) begin : g_copy
        logic [W-1:0] r_q;
        logic [W-1:0] nxt;

        // Per-copy voter placed directly after the registers.
        tmr_vote3 #(.W(W)) u_vote (
            .a (cur[0]),
            .b (cur[1]),
            .c (cur[2]),
            .y (voted[c])
        );

        if (KIND == STG_ACCUM) begin : g_acc
            // Accumulate into the voted copy when enabled, else keep it.
            always_comb begin
                nxt = en ? (voted[c] + d[c]) : voted[c];
            end
        end else begin : g_hold
            // Load the new input when enabled, else refresh from the vote.
            always_comb begin
                nxt = en ? d[c] : voted[c];
            end
        end

        // Store the next state of this copy, inverted on fault injection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_q <= '0;
            end else begin
                r_q <= nxt ^ {W{flip[c]}};
            end
        end

        assign cur[c] = r_q;
    end

    assign q = voted;

    // Flag any difference between the three stored copies.
    always_comb begin
        disagree = (cur[0] != cur[1]) || (cur[1] != cur[2]);
    end

endmodule

// File: rtl/tmr_pipe_chain.sv
// Module: top of the triple-redundant register pipeline.
// The single input word is fanned out to three copies. Stage 0 is an
// unvoted always-enabled register, middle stages are voted enabled
// registers, and the last stage is a voted accumulator. A merging voter
// produces the single output. Assumes one shared clock and the single-upset
// fault model (one flip bit at a time, spaced by three clear edges).
module tmr_pipe_chain
    import tmr_pipe_pkg::*;
#(
    parameter int W      = 8,
    parameter int STAGES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [W-1:0]          din,
    input  logic                  adv,
    input  logic [3*STAGES-1:0]   flip,
    output logic [W-1:0]          dout,
    output logic                  mismatch
);

    localparam int NFLIP = 3 * STAGES;

    logic [STAGES:0][2:0][W-1:0] link;
    logic [STAGES-1:0]           stage_dis;

    // Fan the single input word out to all three copies.
    assign link[0] = {3{din}};

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [2:0][W-1:0] q_s;
        logic              dis_s;

        if (s == 0 && STAGES > 1) begin : g_raw
            tmr_stage_raw #(.W(W)) u_stage (
                .clk      (clk),
                .rst_n    (rst_n),
                .flip     (flip[s*3 +: 3]),
                .d        (link[s]),
                .q        (q_s),
                .disagree (dis_s)
            );
        end else if (s == STAGES - 1) begin : g_acc
            tmr_stage_voted #(.W(W), .KIND(STG_ACCUM)) u_stage (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (adv),
                .flip     (flip[s*3 +: 3]),
                .d        (link[s]),
                .q        (q_s),
                .disagree (dis_s)
            );
        end else begin : g_hold
            tmr_stage_voted #(.W(W), .KIND(STG_HOLD)) u_stage (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (adv),
                .flip     (flip[s*3 +: 3]),
                .d        (link[s]),
                .q        (q_s),
                .disagree (dis_s)
            );
        end

        assign link[s+1]    = q_s;
        assign stage_dis[s] = dis_s;
    end

    // Merge the three accumulator copies into the single-copy output.
    tmr_vote3 #(.W(W)) u_merge (
        .a (link[STAGES][0]),
        .b (link[STAGES][1]),
        .c (link[STAGES][2]),
        .y (dout)
    );

    // Raise the disagreement flag when any stage has differing copies.
    always_comb begin
        mismatch = |stage_dis;
    end

    if (NFLIP < 3) begin : g_bad_param
        initial $error("STAGES must be at least 1");
    end

endmodule

// File: rtl/tmr_pipe_chain_chk.sv
// Module: assertion checker bound to tmr_pipe_chain.
// Watches the ports only; assumes the single-upset stimulus model.
module tmr_pipe_chain_chk #(
    parameter int W      = 8,
    parameter int STAGES = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [W-1:0]          din,
    input logic                  adv,
    input logic [3*STAGES-1:0]   flip,
    input logic [W-1:0]          dout,
    input logic                  mismatch
);

    logic [1:0] gap_q;

    // Count clear edges since the last injected flip, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= 2'd3;
        end else if (|flip) begin
            gap_q <= 2'd0;
        end else if (gap_q != 2'd3) begin
            gap_q <= gap_q + 2'd1;
        end
    end

    // R2: the cycle after reset is released, output and flag are clear.
    p_reset_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dout == '0 && !mismatch));

    // R6: never more than one copy upset in one edge.
    p_single_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flip));

    // R6: upsets are separated by at least three clear edges.
    p_flip_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|flip) |-> (gap_q == 2'd3));

    // R4 and R1: with advance low the merged output holds, faults or not.
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(dout));

    // R7: an injected flip is visible as a disagreement in the next cycle.
    p_flip_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|flip) |=> mismatch);

    // R3: unused input kept visible to the checker for debug only.
    logic unused_din;
    assign unused_din = ^din;

endmodule

bind tmr_pipe_chain tmr_pipe_chain_chk #(.W(W), .STAGES(STAGES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .adv      (adv),
    .flip     (flip),
    .dout     (dout),
    .mismatch (mismatch)
);

// File: tb/sim_tmr_pipe_chain.sv
// Bench: table-driven plus directed tests for tmr_pipe_chain (8 bits,
// 4 stages). Expected values come from a fault-free behavioural model
// written from the requirements.
module sim_tmr_pipe_chain;

    localparam int W  = 8;
    localparam int S  = 4;
    localparam int NF = 3 * S;
    localparam int NV = 18;

    logic          clk;
    logic          rst_n;
    logic [W-1:0]  din;
    logic          adv;
    logic [NF-1:0] flip;
    logic [W-1:0]  dout;
    logic          mismatch;

    int errs   = 0;
    int checks = 0;
    bit done   = 0;

    tmr_pipe_chain #(.W(W), .STAGES(S)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .adv      (adv),
        .flip     (flip),
        .dout     (dout),
        .mismatch (mismatch)
    );

    // 50 MHz clock.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Fault-free model: stage 0 always loads, middle stages and the
    // accumulator move on adv; expected flag from the injection pattern.
    logic [W-1:0] m0, m1, m2, macc;
    logic         exp_mm, s0f;
    always @(posedge clk) begin
        if (!rst_n) begin
            m0 <= '0; m1 <= '0; m2 <= '0; macc <= '0;
            exp_mm <= 1'b0; s0f <= 1'b0;
        end else begin
            m0 <= din;
            if (adv) begin
                m1   <= m0;
                m2   <= m1;
                macc <= macc + m2;
            end
            exp_mm <= (|flip) || (s0f && adv);
            s0f    <= |flip[2:0];
        end
    end

    // Stimulus table: {din, adv, flip}; flips four entries apart.
    localparam logic [W+NF:0] VEC [NV] = '{
        {8'h01, 1'b1, 12'h000}, {8'h02, 1'b1, 12'h000},
        {8'h03, 1'b1, 12'h001}, {8'h04, 1'b1, 12'h000},
        {8'h05, 1'b0, 12'h000}, {8'h06, 1'b1, 12'h000},
        {8'h07, 1'b1, 12'h010}, {8'h08, 1'b0, 12'h000},
        {8'h09, 1'b1, 12'h000}, {8'h0A, 1'b1, 12'h000},
        {8'h0B, 1'b0, 12'h100}, {8'h0C, 1'b1, 12'h000},
        {8'h0D, 1'b1, 12'h000}, {8'h0E, 1'b1, 12'h000},
        {8'hF0, 1'b1, 12'h200}, {8'hF1, 1'b0, 12'h000},
        {8'hF2, 1'b1, 12'h000}, {8'hF3, 1'b1, 12'h000}
    };

    task automatic chk(input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Apply one set of inputs, wait one cycle, compare at the falling edge.
    task automatic drive(input logic [W-1:0] d, input logic a,
                         input logic [NF-1:0] f, input string tag);
        din  = d;
        adv  = a;
        flip = f;
        @(negedge clk);
        chk(tag, dout, macc);
        chk("R7 mismatch", {7'd0, mismatch}, {7'd0, exp_mm});
        flip = '0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        rst_n = 1'b0;
        din   = '0;
        adv   = 1'b0;
        flip  = '0;
        repeat (3) @(negedge clk);
        // R2: reset state of output and flag.
        chk("R2 dout", dout, '0);
        chk("R2 mismatch", {7'd0, mismatch}, 8'd0);
        rst_n = 1'b1;

        // Table walk: R3 enables, R5 latency, R6 masked upsets.
        for (int i = 0; i < NV; i++) begin
            logic [W-1:0]  vd;
            logic          va;
            logic [NF-1:0] vf;
            {vd, va, vf} = VEC[i];
            drive(vd, va, vf, (vf != '0) ? "R6" : (va ? "R5" : "R3"));
        end

        // R4: wrap of the accumulator modulo 2^W.
        for (int i = 0; i < 6; i++) drive(8'hFF, 1'b1, '0, "R4 wrap");

        // R1: accumulator copy upset while holding; merged output unchanged.
        drive(8'h00, 1'b0, 12'h800, "R1 hold upset");
        for (int i = 0; i < 3; i++) drive(8'h00, 1'b0, '0, "R4 hold");

        // R7: stage-0 upset followed by adv low only flags for one cycle.
        drive(8'h55, 1'b1, 12'h002, "R6 stage0");
        drive(8'h66, 1'b0, '0, "R7 short");
        drive(8'h77, 1'b0, '0, "R3 hold");
        drive(8'h88, 1'b1, '0, "R3 move");

        // R2: reset in the middle of a run clears everything.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R2 mid dout", dout, '0);
        chk("R2 mid mismatch", {7'd0, mismatch}, 8'd0);

        // R5: single value travels to the accumulator after three more edges.
        drive(8'h07, 1'b1, '0, "R5 lat");
        for (int i = 0; i < 4; i++) drive(8'h00, 1'b1, '0, "R5 lat");
        chk("R5 final", dout, 8'h07);

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule